// File: doc/BRIEF.md
# Battery-Backed Flag and Control Register Bank

This block holds the small set of registers that sit at the top of the address space of a battery-backed timekeeping device. One register carries a sticky battery-low status bit together with the alarm enables and a few scratch bits. A second register holds the write-hold, read-hold and frequency-test controls and a calibration field. A third holds the watchdog steering, multiplier and resolution fields. Software reaches them over a simple address/data bus with read and write strobes.

Each register bit belongs to one of several reset classes. A battery attach clears everything. A power-up or an explicit reset request clears the alarm, watchdog and clock-control bits and keeps the scratch and calibration fields. A power-down clears only the clock-control and watchdog bits. The battery-low status bit is not reset by power-up. It is loaded from a digital comparator input in a single check cycle that follows each rise of the VCC-good input. It is read-only on the bus.

Top module: `rkeep_bank`

## Requirements
- R1: After a battery attach (`batt_attach` high for one clock), every field of all three registers reads 0, including the battery-low bit, until a power-up check loads it.
- R2: The battery-low bit is bit 4 of the status register at address 0x7FF0. The comparator input `batt_low_in` (1 = battery below threshold) is copied into it at the second rising clock edge at which `vcc_good` is high after being low.
- R3: At every other edge `batt_low_in` is ignored. The battery-low bit holds through power-down, battery backup and reset requests. Only the next power-up check or a battery attach changes it.
- R4: The battery-low bit is read-only. A write to 0x7FF0 updates only bit 7 (alarm flag enable), bit 6 (alarm battery enable) and bits 3:0 (scratch). Bit 5 always reads 0.
- R5: Power-up clears W, R, FT, both alarm enables and the whole watchdog register. The scratch bits (0x7FF0[3:0]) and the calibration field (0x7FF1[4:0]) keep their values.
- R6: A reset request (`rst_req` high for one clock) clears the same bits as a power-up but does not run a battery check.
- R7: Power-down (the first edge at which `vcc_good` is seen low after being high) clears W, R, FT and the watchdog register. The alarm enables, scratch and calibration fields are kept.
- R8: While `vcc_good` is low, reads return 0 and writes are ignored.
- R9: Reads of any address other than 0x7FF0 to 0x7FF2 return 0, and writes to such addresses change nothing.
- R10: Layout of 0x7FF1: bit 7 W, bit 6 R, bit 5 FT, bits 4:0 calibration. Layout of 0x7FF2: bit 7 steering, bits 6:2 multiplier, bits 1:0 resolution. Both registers are fully readable and writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| batt_attach | input | 1 | Battery attach pulse; clears every register bit |
| vcc_good | input | 1 | Supply at nominal level; its edges mark power-up and power-down |
| rst_req | input | 1 | Reset request pulse; same clearing as a power-up |
| batt_low_in | input | 1 | Battery comparator output, 1 = battery low |
| addr | input | 15 | Bus address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational, 0 when not reading |

## Verification
A wrong reset class leaves stale ones in the control or watchdog readback on the first read after the power event. Such an error shows within two clocks of the event. A mistimed comparator sample shows up in the battery-low bit at the next status read, because the bench holds the opposite comparator value on the edges before and after the sampling edge. A battery-low bit that a write can reach, or that a reset class can clear, shows up on the status read that follows that write or event.

// File: rtl/rkeep_pkg.sv
package rkeep_pkg;
   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_ATTACH = 2'd1,
      EV_PDOWN  = 2'd2,
      EV_PUP    = 2'd3
   } ev_cls_t;

   typedef struct packed {
      logic       afe;
      logic       abe;
      logic [3:0] usr;
      logic       w;
      logic       r;
      logic       ft;
      logic [4:0] cal;
      logic       steer;
      logic [4:0] mult;
      logic [1:0] res;
   } regs_t;

   localparam int STAT_AFE_BIT = 7;
   localparam int STAT_ABE_BIT = 6;
   localparam int STAT_BL_BIT  = 4;
endpackage

// File: rtl/rkeep_pwr_seq.sv
module rkeep_pwr_seq
   import rkeep_pkg::*;
(
   input  logic    clk,
   input  logic    batt_attach,
   input  logic    vcc_good,
   input  logic    rst_req,
   output ev_cls_t ev_cls,
   output logic    chk_stb
);
   logic vcc_q;
   logic chk_q;
   logic pu_edge;
   logic pd_edge;

   assign pu_edge = vcc_good & ~vcc_q;
   assign pd_edge = ~vcc_good & vcc_q;

   always_ff @(posedge clk) begin
      if (batt_attach) begin
         vcc_q <= 1'b0;
         chk_q <= 1'b0;
      end else begin
         vcc_q <= vcc_good;
         chk_q <= pu_edge;
      end
   end

   assign chk_stb = chk_q & vcc_good & ~batt_attach;

   always_comb begin
      if (batt_attach)               ev_cls = EV_ATTACH;
      else if (pd_edge)              ev_cls = EV_PDOWN;
      else if (pu_edge || rst_req)   ev_cls = EV_PUP;
      else                           ev_cls = EV_NONE;
   end
endmodule

// File: rtl/rkeep_batt_flag.sv
module rkeep_batt_flag (
   input  logic clk,
   input  logic batt_attach,
   input  logic chk_stb,
   input  logic batt_low_in,
   output logic bl_q
);
   always_ff @(posedge clk) begin
      if (batt_attach)  bl_q <= 1'b0;
      else if (chk_stb) bl_q <= batt_low_in;
   end
endmodule

// File: rtl/rkeep_ctl_regs.sv
module rkeep_ctl_regs
   import rkeep_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit ATTACH_ONES = 1'b0
) (
   input  logic              clk,
   input  ev_cls_t           ev_cls,
   input  logic              wr_stat,
   input  logic              wr_ctl,
   input  logic              wr_wd,
   input  logic [DATA_W-1:0] wr_data,
   output regs_t             regs_q
);
   localparam int REGS_W = $bits(regs_t);

   regs_t fill;
   regs_t nxt;

   generate
      if (ATTACH_ONES) begin : g_fill_ones
         assign fill = regs_t'({REGS_W{1'b1}});
      end else begin : g_fill_zero
         assign fill = regs_t'({REGS_W{1'b0}});
      end
   endgenerate

   always_comb begin
      nxt = regs_q;
      unique case (ev_cls)
         EV_ATTACH: begin
            nxt       = fill;
            nxt.w     = 1'b0;
            nxt.r     = 1'b0;
            nxt.ft    = 1'b0;
            nxt.afe   = 1'b0;
            nxt.abe   = 1'b0;
            nxt.steer = 1'b0;
            nxt.mult  = '0;
            nxt.res   = '0;
         end
         EV_PUP: begin
            nxt.w     = 1'b0;
            nxt.r     = 1'b0;
            nxt.ft    = 1'b0;
            nxt.afe   = 1'b0;
            nxt.abe   = 1'b0;
            nxt.steer = 1'b0;
            nxt.mult  = '0;
            nxt.res   = '0;
         end
         EV_PDOWN: begin
            nxt.w     = 1'b0;
            nxt.r     = 1'b0;
            nxt.ft    = 1'b0;
            nxt.steer = 1'b0;
            nxt.mult  = '0;
            nxt.res   = '0;
         end
         default: begin
            if (wr_stat) begin
               nxt.afe = wr_data[STAT_AFE_BIT];
               nxt.abe = wr_data[STAT_ABE_BIT];
               nxt.usr = wr_data[3:0];
            end
            if (wr_ctl) begin
               nxt.w   = wr_data[7];
               nxt.r   = wr_data[6];
               nxt.ft  = wr_data[5];
               nxt.cal = wr_data[4:0];
            end
            if (wr_wd) begin
               nxt.steer = wr_data[7];
               nxt.mult  = wr_data[6:2];
               nxt.res   = wr_data[1:0];
            end
         end
      endcase
   end

   always_ff @(posedge clk) regs_q <= nxt;
endmodule

// File: rtl/rkeep_bank.sv
module rkeep_bank
   import rkeep_pkg::*;
#(
   parameter int                ADDR_W      = 15,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 15'h7FF0,
   parameter bit                ATTACH_ONES = 1'b0
) (
   input  logic              clk,
   input  logic              batt_attach,
   input  logic              vcc_good,
   input  logic              rst_req,
   input  logic              batt_low_in,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR;
   localparam logic [ADDR_W-1:0] CTL_ADDR  = BASE_ADDR + ADDR_W'(1);
   localparam logic [ADDR_W-1:0] WD_ADDR   = BASE_ADDR + ADDR_W'(2);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("rkeep_bank: register layout needs DATA_W == 8");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("rkeep_bank: ADDR_W too small");
      end
   endgenerate

   ev_cls_t ev_cls;
   logic    chk_stb;
   logic    bl_q;
   regs_t   regs_q;
   logic    bus_ok;
   logic    hit_stat, hit_ctl, hit_wd;

   assign bus_ok   = vcc_good;
   assign hit_stat = (addr == STAT_ADDR);
   assign hit_ctl  = (addr == CTL_ADDR);
   assign hit_wd   = (addr == WD_ADDR);

   rkeep_pwr_seq u_seq (
      .clk         (clk),
      .batt_attach (batt_attach),
      .vcc_good    (vcc_good),
      .rst_req     (rst_req),
      .ev_cls      (ev_cls),
      .chk_stb     (chk_stb)
   );

   rkeep_batt_flag u_flag (
      .clk         (clk),
      .batt_attach (batt_attach),
      .chk_stb     (chk_stb),
      .batt_low_in (batt_low_in),
      .bl_q        (bl_q)
   );

   rkeep_ctl_regs #(
      .DATA_W      (DATA_W),
      .ATTACH_ONES (ATTACH_ONES)
   ) u_regs (
      .clk     (clk),
      .ev_cls  (ev_cls),
      .wr_stat (bus_ok & wr_en & hit_stat),
      .wr_ctl  (bus_ok & wr_en & hit_ctl),
      .wr_wd   (bus_ok & wr_en & hit_wd),
      .wr_data (wr_data),
      .regs_q  (regs_q)
   );

   always_comb begin
      rd_data = '0;
      if (bus_ok && rd_en) begin
         if (hit_stat) rd_data = {regs_q.afe, regs_q.abe, 1'b0, bl_q, regs_q.usr};
         else if (hit_ctl) rd_data = {regs_q.w, regs_q.r, regs_q.ft, regs_q.cal};
         else if (hit_wd) rd_data = {regs_q.steer, regs_q.mult, regs_q.res};
      end
   end
endmodule

// File: rtl/rkeep_bank_chk.sv
module rkeep_bank_chk
   import rkeep_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              batt_attach,
   input logic              vcc_good,
   input logic              batt_low_in,
   input logic [DATA_W-1:0] rd_data,
   input ev_cls_t           ev_cls,
   input logic              chk_stb,
   input logic              bl_q,
   input regs_t             regs_q
);
   logic armed = 1'b0;
   always_ff @(posedge clk) if (batt_attach) armed <= 1'b1;

   assert_bl_load_R2: assert property (@(posedge clk) disable iff (batt_attach || !armed)
      chk_stb |=> (bl_q == $past(batt_low_in)));

   assert_bl_hold_R3: assert property (@(posedge clk) disable iff (batt_attach || !armed)
      (bl_q != $past(bl_q)) |-> ($past(chk_stb) || $past(batt_attach)));

   assert_pup_clear_R5: assert property (@(posedge clk) disable iff (batt_attach || !armed)
      (ev_cls == EV_PUP) |=> (!regs_q.w && !regs_q.r && !regs_q.ft && !regs_q.afe &&
                              !regs_q.abe && !regs_q.steer && regs_q.mult == '0 &&
                              regs_q.res == '0));

   assert_pdown_class_R7: assert property (@(posedge clk) disable iff (batt_attach || !armed)
      (ev_cls == EV_PDOWN) |=> (!regs_q.w && !regs_q.r && !regs_q.ft && !regs_q.steer &&
                                regs_q.mult == '0 && regs_q.res == '0 &&
                                regs_q.afe == $past(regs_q.afe) &&
                                regs_q.abe == $past(regs_q.abe) &&
                                regs_q.cal == $past(regs_q.cal)));

   assert_bus_blocked_R8: assert property (@(posedge clk) disable iff (!armed)
      !vcc_good |-> (rd_data == '0));
endmodule

bind rkeep_bank rkeep_bank_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .batt_attach (batt_attach),
   .vcc_good    (vcc_good),
   .batt_low_in (batt_low_in),
   .rd_data     (rd_data),
   .ev_cls      (ev_cls),
   .chk_stb     (chk_stb),
   .bl_q        (bl_q),
   .regs_q      (regs_q)
);

// File: tb/tb_rkeep_bank.sv
module tb_rkeep_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        batt_attach = 1'b0;
   logic        vcc_good = 1'b0;
   logic        rst_req = 1'b0;
   logic        batt_low_in = 1'b0;
   logic [14:0] addr = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rkeep_bank dut (
      .clk (clk), .batt_attach (batt_attach), .vcc_good (vcc_good),
      .rst_req (rst_req), .batt_low_in (batt_low_in), .addr (addr),
      .wr_en (wr_en), .rd_en (rd_en), .wr_data (wr_data), .rd_data (rd_data)
   );

   task automatic check_rd(input logic [14:0] a, input logic [7:0] exp, input string req);
      logic [7:0] got;
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 got = rd_data;
      rd_en = 1'b0;
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, a, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [14:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_attach();
      @(negedge clk); batt_attach = 1'b1;
      @(negedge clk); batt_attach = 1'b0;
   endtask

   task automatic power_down();
      @(negedge clk); vcc_good = 1'b0;
      @(negedge clk);
   endtask

   // comparator differs from v at every edge but the sampling edge
   task automatic power_up(input logic v);
      @(negedge clk); vcc_good = 1'b1; batt_low_in = ~v;
      @(negedge clk); batt_low_in = v;
      @(negedge clk); batt_low_in = ~v;
      @(negedge clk);
   endtask

   task automatic t_attach_defaults();
      vcc_good = 1'b0;
      do_attach();
      power_up(1'b0);
      check_rd(15'h7FF0, 8'h00, "R1 status after attach");
      check_rd(15'h7FF1, 8'h00, "R1 control after attach");
      check_rd(15'h7FF2, 8'h00, "R1 watchdog after attach");
   endtask

   task automatic t_low_battery();
      power_down();
      power_up(1'b1);
      check_rd(15'h7FF0, 8'h10, "R2 R3 battery low latched at check edge");
   endtask

   task automatic t_flag_readonly();
      bus_wr(15'h7FF0, 8'hFF);
      check_rd(15'h7FF0, 8'hDF, "R4 write ones keeps flag, bit5 zero");
      bus_wr(15'h7FF0, 8'h00);
      check_rd(15'h7FF0, 8'h10, "R4 write zeros keeps flag");
   endtask

   task automatic t_layout();
      bus_wr(15'h7FF1, 8'hE5);
      check_rd(15'h7FF1, 8'hE5, "R10 control readback");
      bus_wr(15'h7FF2, 8'hAB);
      check_rd(15'h7FF2, 8'hAB, "R10 watchdog readback");
   endtask

   task automatic t_reset_req();
      bus_wr(15'h7FF0, 8'hCA);
      check_rd(15'h7FF0, 8'hDA, "R4 enables and scratch written");
      @(negedge clk); rst_req = 1'b1; batt_low_in = 1'b0;
      @(negedge clk); rst_req = 1'b0;
      @(negedge clk);
      check_rd(15'h7FF0, 8'h1A, "R6 R3 reset keeps flag and scratch");
      check_rd(15'h7FF1, 8'h05, "R6 reset keeps calibration");
      check_rd(15'h7FF2, 8'h00, "R6 reset clears watchdog");
   endtask

   task automatic t_power_cycle();
      bus_wr(15'h7FF0, 8'hC3);
      bus_wr(15'h7FF1, 8'hF3);
      bus_wr(15'h7FF2, 8'hFF);
      power_down();
      check_rd(15'h7FF1, 8'h00, "R8 read blocked while supply low");
      bus_wr(15'h7FF1, 8'h00);
      @(negedge clk); batt_low_in = 1'b0;
      @(negedge clk); batt_low_in = 1'b1;
      power_up(1'b0);
      check_rd(15'h7FF0, 8'h03, "R5 R7 R3 scratch kept, enables and flag cleared");
      check_rd(15'h7FF1, 8'h13, "R5 R7 R8 calibration kept, blocked write ignored");
      check_rd(15'h7FF2, 8'h00, "R5 R7 watchdog cleared");
   endtask

   task automatic t_unmapped();
      bus_wr(15'h7FF3, 8'hFF);
      bus_wr(15'h0000, 8'hFF);
      check_rd(15'h7FF3, 8'h00, "R9 unmapped read 7FF3");
      check_rd(15'h0000, 8'h00, "R9 unmapped read 0000");
      check_rd(15'h7FF0, 8'h03, "R9 status unchanged");
      check_rd(15'h7FF1, 8'h13, "R9 control unchanged");
      check_rd(15'h7FF2, 8'h00, "R9 watchdog unchanged");
   endtask

   task automatic t_reattach();
      power_down();
      do_attach();
      power_up(1'b1);
      check_rd(15'h7FF0, 8'h10, "R1 R2 attach then low check");
      check_rd(15'h7FF1, 8'h00, "R1 attach clears calibration");
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_attach_defaults();
      t_low_battery();
      t_flag_readonly();
      t_layout();
      t_reset_req();
      t_power_cycle();
      t_unmapped();
      t_reattach();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule